// File: doc/BRIEF.md
# Staged Output Update Controller

This block decides when bytes written over a serial control bus reach the output registers of a five-bank general-purpose I/O port. The bus slave hands it each received data byte with the bank it targets, then an acknowledge strobe once the byte has been accepted, and a stop strobe when the bus transaction ends. The block holds the committed output value of every bank. The bus bit-level timing is handled elsewhere.

A mode input picks between two update policies. In acknowledge mode, each bank's output register changes as soon as the byte for it is acknowledged, so the banks change one at a time. In stop mode, acknowledged bytes go into a staging buffer that has one entry per bank. A pending flag marks each entry that has been written. When the stop strobe arrives, every pending bank is copied to its output register in the same clock edge, and banks that were not written keep their old values. If the writer's auto-incrementing bank index wraps past the last bank, later bytes overwrite earlier staged entries. A repeated start (no stop) leaves the staged entries waiting.

Top module: `staged_out_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all output banks read 0 and no staged entry is pending, so a stop strobe with no writes changes nothing.
- R2: With `stop_mode`=0, a byte presented with `wr_stb` is held, and an `ack_stb` in a later cycle loads it into its bank's output on that clock edge. The value is visible from the next cycle. Other banks stay unchanged.
- R3: An `ack_stb` with no byte held since the previous acknowledge (or since reset) changes no output.
- R4: With `stop_mode`=1, an acknowledged byte is staged and no output changes until a stop strobe.
- R5: A stop strobe loads every pending bank's staged byte into its output on one edge. Banks with no pending entry keep their previous output.
- R6: A second acknowledged byte to the same bank before the stop replaces the staged entry, and only the latest value is committed.
- R7: Idle cycles or further acknowledged bytes without a stop (a repeated start) do not commit. Earlier staged entries remain pending until the next stop.
- R8: A byte whose bank index is 5, 6 or 7 (no such bank) is discarded at its acknowledge and changes no output or staged entry.
- R9: A stop clears all pending flags, so a later stop without new writes changes no output.
- R10: In stop mode, an acknowledge and a stop in the same cycle commit the byte being acknowledged together with the other pending entries.
- R11: An acknowledged byte in acknowledge mode cancels any pending staged entry for that bank, so a later stop does not restore the older staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_mode | input | 1 | 0: update on acknowledge, 1: update all banks on stop |
| wr_stb | input | 1 | A data byte has been received |
| wr_bank | input | 3 | Target bank index of the received byte (0 to 4 valid) |
| wr_data | input | 8 | Received data byte |
| ack_stb | input | 1 | The held byte has been acknowledged |
| stop_stb | input | 1 | Bus stop condition seen |
| out_q | output | 40 | Committed output registers, bank b at bits [8b+7:8b] |

## Verification
A wrong held byte or bank index shows up on the output one cycle after the acknowledge in acknowledge mode. In stop mode it stays hidden until the stop edge. A pending flag that is set or cleared wrongly shows only at a stop: either a bank that should keep its value changes, or a bank that should update does not. For this reason the bench sweeps every subset of the five banks through a stop and compares all five outputs afterwards. It also checks outputs every cycle before the stop, so that any early commit is caught on the cycle it happens.

// File: rtl/staged_pkg.sv
// Shared definitions for the staged output update controller.
// Assumes nothing beyond a single clock domain.
package staged_pkg;
    typedef enum logic {
        UPD_ON_ACK  = 1'b0,
        UPD_ON_STOP = 1'b1
    } upd_mode_e;
endpackage

// File: rtl/byte_latch.sv
// Holds the last received byte and its bank until it is acknowledged.
// Assumes the acknowledge for a byte comes at least one cycle after its write strobe.
module byte_latch #(
    parameter int BIDX_W = 3,
    parameter int BW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BIDX_W-1:0] wr_bank,
    input  logic [BW-1:0]     wr_data,
    input  logic              ack_stb,
    output logic              hv,
    output logic [BIDX_W-1:0] hbank,
    output logic [BW-1:0]     hdata
);
    // Capture a new byte, or drop the held one once it has been acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv    <= 1'b0;
            hbank <= '0;
            hdata <= '0;
        end else if (wr_stb) begin
            hv    <= 1'b1;
            hbank <= wr_bank;
            hdata <= wr_data;
        end else if (ack_stb) begin
            hv <= 1'b0;
        end
    end

    // R3
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !wr_stb) |=> !hv);
    // R2
    hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (hv && hdata == $past(wr_data)));
endmodule

// File: rtl/stage_buf.sv
// Per-bank staging buffer with pending flags, used in stop mode.
// Assumes sel is one-hot or zero. It produces the next staged values and the commit mask
// so that a byte acknowledged in the same cycle as a stop is included in the commit.
module stage_buf #(
    parameter int NBANK = 5,
    parameter int BW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_mode,
    input  logic [NBANK-1:0]    sel,
    input  logic [BW-1:0]       hdata,
    input  logic                stop_stb,
    output logic [NBANK-1:0]    commit,
    output logic [NBANK*BW-1:0] stage_nx
);
    import staged_pkg::*;

    logic [BW-1:0]    stage_q [NBANK];
    logic [NBANK-1:0] pend_q;
    logic [NBANK-1:0] pend_nx;
    logic [NBANK-1:0] stage_we;
    logic [NBANK-1:0] cancel;

    assign stage_we = (upd_mode_e'(stop_mode) == UPD_ON_STOP) ? sel : '0;
    assign cancel   = (upd_mode_e'(stop_mode) == UPD_ON_ACK)  ? sel : '0;

    // Mark banks written in stop mode and clear banks overwritten directly.
    always_comb begin
        pend_nx = (pend_q | stage_we) & ~cancel;
        commit  = stop_stb ? pend_nx : '0;
    end

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            assign stage_nx[b*BW +: BW] = stage_we[b] ? hdata : stage_q[b];

            // Keep the staged byte of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[b] <= '0;
                else        stage_q[b] <= stage_nx[b*BW +: BW];
            end
        end
    endgenerate

    // Track pending banks, all cleared by a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (stop_stb) pend_q <= '0;
        else               pend_q <= pend_nx;
    end

    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> (pend_q == '0));
    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !stop_stb && (sel != '0)) |=> ((pend_q & $past(sel)) != '0));
    // R11
    pend_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_mode && (sel != '0)) |=> ((pend_q & $past(sel)) == '0));
endmodule

// File: rtl/out_regs.sv
// Committed output registers, one byte per bank.
// Assumes imm_sel and commit never select the same bank in one cycle.
module out_regs #(
    parameter int NBANK = 5,
    parameter int BW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NBANK-1:0]    imm_sel,
    input  logic [NBANK-1:0]    commit,
    input  logic [BW-1:0]       hdata,
    input  logic [NBANK*BW-1:0] stage_nx,
    output logic [NBANK*BW-1:0] out_q
);
    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            // Load the bank directly on acknowledge, or from the staging buffer on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)          out_q[b*BW +: BW] <= '0;
                else if (imm_sel[b]) out_q[b*BW +: BW] <= hdata;
                else if (commit[b])  out_q[b*BW +: BW] <= stage_nx[b*BW +: BW];
            end

            // R2
            imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                imm_sel[b] |=> (out_q[b*BW +: BW] == $past(hdata)));
            // R5
            commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                commit[b] |=> (out_q[b*BW +: BW] == $past(stage_nx[b*BW +: BW])));
            // R4
            hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!imm_sel[b] && !commit[b]) |=> $stable(out_q[b*BW +: BW]));
        end
    endgenerate
endmodule

// File: rtl/staged_out_ctrl.sv
// Top level: decides when acknowledged bytes reach the bank output registers,
// either immediately per bank or together on a stop strobe.
// Assumes strobes are single-cycle pulses from the bus slave in the same clock domain.
module staged_out_ctrl #(
    parameter int NBANK = 5,
    parameter int BW    = 8,
    localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_mode,
    input  logic                wr_stb,
    input  logic [BIDX_W-1:0]   wr_bank,
    input  logic [BW-1:0]       wr_data,
    input  logic                ack_stb,
    input  logic                stop_stb,
    output logic [NBANK*BW-1:0] out_q
);
    logic              hv;
    logic [BIDX_W-1:0] hbank;
    logic [BW-1:0]     hdata;
    logic [NBANK-1:0]  sel;
    logic [NBANK-1:0]  imm_sel;
    logic [NBANK-1:0]  commit;
    logic [NBANK*BW-1:0] stage_nx;

    byte_latch #(.BIDX_W(BIDX_W), .BW(BW)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bank(wr_bank),
        .wr_data(wr_data), .ack_stb(ack_stb), .hv(hv), .hbank(hbank), .hdata(hdata)
    );

    // Decode the acknowledged bank; indices past the last bank select nothing.
    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_sel
            assign sel[b] = ack_stb && hv && (hbank == BIDX_W'(b));
        end
    endgenerate

    assign imm_sel = stop_mode ? '0 : sel;

    stage_buf #(.NBANK(NBANK), .BW(BW)) u_stage (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .sel(sel), .hdata(hdata),
        .stop_stb(stop_stb), .commit(commit), .stage_nx(stage_nx)
    );

    out_regs #(.NBANK(NBANK), .BW(BW)) u_out (
        .clk(clk), .rst_n(rst_n), .imm_sel(imm_sel), .commit(commit),
        .hdata(hdata), .stage_nx(stage_nx), .out_q(out_q)
    );

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R10
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((imm_sel & commit) == '0));
endmodule

// File: tb/sim_staged_out_ctrl.sv
module sim_staged_out_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_mode = 1'b0;
    logic        wr_stb = 1'b0;
    logic [2:0]  wr_bank = '0;
    logic [7:0]  wr_data = '0;
    logic        ack_stb = 1'b0;
    logic        stop_stb = 1'b0;
    logic [39:0] out_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] out_m [5];
    logic [7:0] stage_m [5];
    logic [4:0] pend_m;
    logic       hv_m;
    logic [2:0] hb_m;
    logic [7:0] hd_m;

    always #4 clk = ~clk;

    staged_out_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .wr_stb(wr_stb),
        .wr_bank(wr_bank), .wr_data(wr_data), .ack_stb(ack_stb),
        .stop_stb(stop_stb), .out_q(out_q)
    );

    task automatic check_all(input string tag);
        for (int b = 0; b < 5; b++) begin
            checks++;
            if (out_q[b*8 +: 8] !== out_m[b]) begin
                errors++;
                $display("FAIL %s bank %0d: actual %02h expected %02h", tag, b, out_q[b*8 +: 8], out_m[b]);
            end
        end
    endtask

    // One clock: drive inputs, advance to the next falling edge, update the model, check.
    task automatic cyc(input bit wr, input int bank, input int data,
                       input bit ack, input bit stp, input string tag);
        bit   acc;
        wr_stb   = wr;
        wr_bank  = 3'(bank);
        wr_data  = 8'(data);
        ack_stb  = ack;
        stop_stb = stp;
        @(negedge clk);
        acc = ack && hv_m && (hb_m < 3'd5);
        if (acc && !stop_mode) begin
            out_m[hb_m] = hd_m;
            pend_m[hb_m] = 1'b0;
        end
        if (acc && stop_mode) begin
            stage_m[hb_m] = hd_m;
            pend_m[hb_m] = 1'b1;
        end
        if (stp) begin
            for (int b = 0; b < 5; b++)
                if (pend_m[b]) out_m[b] = stage_m[b];
            pend_m = '0;
        end
        if (wr) begin
            hv_m = 1'b1; hb_m = 3'(bank); hd_m = 8'(data);
        end else if (ack) begin
            hv_m = 1'b0;
        end
        check_all(tag);
    endtask

    task automatic put(input int bank, input int data, input string tag);
        cyc(1'b1, bank, data, 1'b0, 1'b0, tag);
        cyc(1'b0, 0, 0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        for (int b = 0; b < 5; b++) begin out_m[b] = '0; stage_m[b] = '0; end
        pend_m = '0; hv_m = 1'b0; hb_m = '0; hd_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R1 stop after reset");

        // R2: every bank under several data patterns, acknowledge mode
        stop_mode = 1'b0;
        for (int b = 0; b < 5; b++)
            for (int k = 0; k < 8; k++)
                put(b, (b * 37 + k * 53 + 1) & 255, "R2 ack update");
        // R3: stray acknowledges
        cyc(1'b0, 0, 0, 1'b1, 1'b0, "R3 stray ack");
        cyc(1'b0, 0, 0, 1'b1, 1'b0, "R3 stray ack");
        // R8: bank indices past the end
        for (int b = 5; b < 8; b++) put(b, 8'hA5, "R8 bad bank ack mode");

        // R4/R5: stop mode, staged until stop
        stop_mode = 1'b1;
        put(1, 8'h11, "R4 staged");
        put(3, 8'h33, "R4 staged");
        cyc(1'b0, 0, 0, 1'b0, 1'b0, "R4 no commit yet");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R5 stop commit");
        // R6: overwrite in buffer
        put(0, 8'h5A, "R6 first");
        put(0, 8'hC3, "R6 second");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R6 stop");
        // R6: wrap of the auto-incremented index
        for (int i = 0; i < 7; i++) put(i % 5, 8'h80 + i, "R6 wrap");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R6 wrap stop");
        // R8 in stop mode
        put(6, 8'hEE, "R8 bad bank stop mode");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R8 stop");
        // R7: repeated start, no stop
        put(2, 8'h22, "R7 first txn");
        repeat (3) cyc(1'b0, 0, 0, 1'b0, 1'b0, "R7 repeated start");
        put(4, 8'h44, "R7 second txn");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R7 stop");
        // R9: stop with nothing pending
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R9 empty stop");
        // R10: acknowledge and stop together
        put(2, 8'h7E, "R10 pending");
        cyc(1'b1, 1, 8'h9D, 1'b0, 1'b0, "R10 write");
        cyc(1'b0, 0, 0, 1'b1, 1'b1, "R10 ack+stop");
        // R11: direct update cancels staged entry
        put(3, 8'hB3, "R11 staged");
        stop_mode = 1'b0;
        put(3, 8'h3B, "R11 direct");
        cyc(1'b0, 0, 0, 1'b0, 1'b1, "R11 stop");

        // R5: every subset of banks through a stop
        stop_mode = 1'b1;
        for (int m = 0; m < 32; m++) begin
            for (int b = 0; b < 5; b++)
                if (m[b]) put(b, (m * 7 + b * 29 + 3) & 255, "R5 subset stage");
            cyc(1'b0, 0, 0, 1'b0, 1'b1, "R5 subset stop");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule